// File: doc/BRIEF.md
# Maskable Content-Addressable Match Store

This block is a small associative memory. Each slot holds a key, a data word and a valid bit. Software or a neighbouring engine never gives a slot address when it stores something: a learn command drops the key and data into the lowest-numbered free slot. A search command compares a comparand with every valid slot in the same cycle. Before the compare, one of several mask registers, chosen per search, turns selected key bits into don't-care bits.

The result of a search is latched as a vector of hit slots. The ports report whether any slot matched and whether more than one is still pending. They also give the lowest pending slot's address, its stored key and its data. A next command retires the reported slot from the latched vector and presents the next-higher one. When the vector is empty, the hit output falls. Storing, invalidating or rewriting a mask discards any pending search result.

Top module: `assoc_match_store`

## Requirements
- R1: A learn (op code 1) writes key and data into the lowest-numbered slot whose valid bit is clear and sets that bit. No slot address is supplied.
- R2: A learn when every slot is valid leaves all slots unchanged and sets `learn_fail`. `learn_fail` is updated on every learn and cleared by an invalidate.
- R3: In a mask register, a bit value of 1 makes the corresponding key bit don't-care in the compare. A bit value of 0 makes it significant.
- R4: After a search (op code 2), `hit` is 1 exactly when at least one valid slot matches the masked comparand.
- R5: While `hit` is 1, `hit_addr` is the lowest pending matching slot, and `hit_key` and `hit_data` are that slot's stored key and data.
- R6: `multi_hit` is 1 exactly when two or more matches are still pending.
- R7: A next command (op code 3) removes the reported slot from the pending set, so the slots are reported in ascending address order.
- R8: When no match is pending, `hit` and `multi_hit` are 0, and a further next command leaves them at 0.
- R9: A learn, an invalidate or a mask write discards all pending matches, so `hit` reads 0 in the following cycle.
- R10: An invalidate (op code 4) clears the valid bit of the slot given on `op_addr`. That slot then never matches.
- R11: The 2-bit `op_msel` field selects the mask register used by a search. It also selects the register that a mask write (op code 5) loads from `op_key`.
- R12: After reset, all slots are invalid, all masks are 0, `hit` is 0 and `learn_fail` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Command strobe, one command per cycle |
| op_code | input | 3 | 1 learn, 2 search, 3 next, 4 invalidate, 5 mask write |
| op_key | input | KEY_W | Key for learn, comparand for search, value for mask write |
| op_data | input | DATA_W | Data stored by learn |
| op_addr | input | AW | Slot addressed by invalidate |
| op_msel | input | SW | Mask register select |
| hit | output | 1 | At least one match pending |
| multi_hit | output | 1 | Two or more matches pending |
| hit_addr | output | AW | Lowest pending matching slot |
| hit_key | output | KEY_W | Stored key of that slot |
| hit_data | output | DATA_W | Stored data of that slot |
| learn_fail | output | 1 | Last learn found no free slot |

## Verification
A corrupted slot or a wrong valid bit becomes visible at the next search that touches it: a key, data word or address differs, or `hit` disagrees with the arithmetic model. A wrong pending vector shows in the cycle after a search or next. It appears as a skipped or repeated address during the walk, or as a `multi_hit` value that disagrees with the number of matches left. Every comparand is swept under every mask, each search walked to exhaustion, so a fault in any slot or bit surfaces within one sweep.

// File: rtl/cam_pkg.sv
// Shared command encoding for the match store.
// Assumes a 3-bit command field; unknown codes act as no operation.
package cam_pkg;
    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_LEARN  = 3'd1,
        OP_SEARCH = 3'd2,
        OP_NEXT   = 3'd3,
        OP_DROP   = 3'd4,
        OP_MASKWR = 3'd5
    } cam_op_e;
endpackage

// File: rtl/cam_lowest.sv
// Finds the lowest set bit of a vector.
// Returns its index, a one-hot copy and an any-set flag; idx is 0 when empty.
module cam_lowest #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot,
    output logic          any
);
    // Scan upward and keep the first set position.
    always_comb begin
        idx    = '0;
        onehot = '0;
        any    = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (vec[i] && !any) begin
                idx       = IW'(i);
                onehot[i] = 1'b1;
                any       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cam_slot_array.sv
// Slot storage with one compare unit per slot.
// Assumes at most one write and one clear per cycle; the caller never writes a valid slot.
module cam_slot_array #(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 8,
    parameter int DATA_W  = 8,
    localparam int AW = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [KEY_W-1:0]  wr_key,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              drop_en,
    input  logic [AW-1:0]     drop_idx,
    input  logic [KEY_W-1:0]  cmp_key,
    input  logic [KEY_W-1:0]  cmp_mask,
    input  logic [AW-1:0]     rd_idx,
    output logic [ENTRIES-1:0] valid_vec,
    output logic [ENTRIES-1:0] match_vec,
    output logic [KEY_W-1:0]  rd_key,
    output logic [DATA_W-1:0] rd_data
);
    logic [KEY_W-1:0]  key_q  [ENTRIES];
    logic [DATA_W-1:0] data_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        // Hold one slot's key, data and valid bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_vec[g] <= 1'b0;
                key_q[g]     <= '0;
                data_q[g]    <= '0;
            end else if (wr_en && wr_idx == AW'(g)) begin
                valid_vec[g] <= 1'b1;
                key_q[g]     <= wr_key;
                data_q[g]    <= wr_data;
            end else if (drop_en && drop_idx == AW'(g)) begin
                valid_vec[g] <= 1'b0;
            end
        end
        // Masked compare: mask bit 1 means don't-care.
        assign match_vec[g] = valid_vec[g] && (((key_q[g] ^ cmp_key) & ~cmp_mask) == '0);
    end

    assign rd_key  = key_q[rd_idx];
    assign rd_data = data_q[rd_idx];

    // R1
    free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !valid_vec[wr_idx]);
    // R10
    drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_en && !wr_en |=> !valid_vec[$past(drop_idx)]);
endmodule

// File: rtl/assoc_match_store.sv
// Maskable associative store: learn into first free slot, masked parallel
// search, latched pending-match vector walked in ascending order by next.
// Assumes one command per cycle on op_valid/op_code.
module assoc_match_store
    import cam_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 8,
    parameter int DATA_W  = 8,
    parameter int MASKS   = 4,
    localparam int AW = $clog2(ENTRIES),
    localparam int SW = $clog2(MASKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [KEY_W-1:0]  op_key,
    input  logic [DATA_W-1:0] op_data,
    input  logic [AW-1:0]     op_addr,
    input  logic [SW-1:0]     op_msel,
    output logic              hit,
    output logic              multi_hit,
    output logic [AW-1:0]     hit_addr,
    output logic [KEY_W-1:0]  hit_key,
    output logic [DATA_W-1:0] hit_data,
    output logic              learn_fail
);
    logic [KEY_W-1:0]   mask_q [MASKS];
    logic [ENTRIES-1:0] pend_q;
    logic [ENTRIES-1:0] valid_vec, match_vec, free_hot, pend_hot;
    logic [AW-1:0]      free_idx;
    logic               free_any, pend_any;
    logic               do_learn, do_search, do_next, do_drop, do_maskwr, wr_ok;

    // Decode the command strobe.
    always_comb begin
        do_learn  = op_valid && cam_op_e'(op_code) == OP_LEARN;
        do_search = op_valid && cam_op_e'(op_code) == OP_SEARCH;
        do_next   = op_valid && cam_op_e'(op_code) == OP_NEXT;
        do_drop   = op_valid && cam_op_e'(op_code) == OP_DROP;
        do_maskwr = op_valid && cam_op_e'(op_code) == OP_MASKWR;
        wr_ok     = do_learn && free_any;
    end

    cam_lowest #(.N(ENTRIES)) u_free (
        .vec(~valid_vec), .idx(free_idx), .onehot(free_hot), .any(free_any));

    cam_lowest #(.N(ENTRIES)) u_pend (
        .vec(pend_q), .idx(hit_addr), .onehot(pend_hot), .any(pend_any));

    cam_slot_array #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .DATA_W(DATA_W)) u_slots (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_ok), .wr_idx(free_idx), .wr_key(op_key), .wr_data(op_data),
        .drop_en(do_drop), .drop_idx(op_addr),
        .cmp_key(op_key), .cmp_mask(mask_q[op_msel]),
        .rd_idx(hit_addr),
        .valid_vec(valid_vec), .match_vec(match_vec),
        .rd_key(hit_key), .rd_data(hit_data));

    // Load the selected mask register.
    always_ff @(posedge clk) begin
        for (int m = 0; m < MASKS; m++) begin
            if (!rst_n)
                mask_q[m] <= '0;
            else if (do_maskwr && op_msel == SW'(m))
                mask_q[m] <= op_key;
        end
    end

    // Capture, step or discard the pending-match vector.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else if (do_search)
            pend_q <= match_vec;
        else if (do_next)
            pend_q <= pend_q & ~pend_hot;
        else if (do_learn || do_drop || do_maskwr)
            pend_q <= '0;
    end

    // Record whether the last learn found no free slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            learn_fail <= 1'b0;
        else if (do_learn)
            learn_fail <= !free_any;
        else if (do_drop)
            learn_fail <= 1'b0;
    end

    assign hit       = pend_any;
    assign multi_hit = $countones(pend_q) > 1;

    // R2
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_learn && (&valid_vec) |=> learn_fail && $stable(valid_vec));
    // R1
    learn_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> $countones(valid_vec) == $countones($past(valid_vec)) + 1);
    // R7
    next_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_next && hit |=> $countones(pend_q) == $countones($past(pend_q)) - 1);
    // R9
    pend_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_learn || do_drop || do_maskwr |=> !hit);
    // R6
    multi_imp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        multi_hit |-> hit);
    // R5
    hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_search |=> !hit || valid_vec[hit_addr]);
endmodule

// File: tb/assoc_match_store_test.sv
`timescale 1ns/1ps
// Sweep bench: every comparand under every mask, each search walked to the end.
module assoc_match_store_test;
    localparam int N = 8;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_valid = 1'b0;
    logic [2:0] op_code = '0;
    logic [7:0] op_key = '0, op_data = '0;
    logic [2:0] op_addr = '0;
    logic [1:0] op_msel = '0;
    logic hit, multi_hit, learn_fail;
    logic [2:0] hit_addr;
    logic [7:0] hit_key, hit_data;

    int checks = 0, errors = 0;
    logic [7:0] mkey [N];
    logic [7:0] mdat [N];
    logic [N-1:0] mval = '0, mpend = '0;
    logic [7:0] mmask [4];
    logic mfail = 1'b0;

    always #4 clk = ~clk;

    assoc_match_store uut (.*);

    initial begin
        #1200000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic int low_of(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    // Model update from pre-edge state, then drive and wait for the edge.
    task automatic do_op(input logic [2:0] c, input logic [7:0] k, input logic [7:0] d,
                         input logic [2:0] a, input logic [1:0] s);
        int f;
        case (c)
            3'd1: begin
                f = low_of(~mval);
                mpend = '0;
                if (f < 0) mfail = 1'b1;
                else begin mfail = 1'b0; mval[f] = 1'b1; mkey[f] = k; mdat[f] = d; end
            end
            3'd2: for (int e = 0; e < N; e++)
                      mpend[e] = mval[e] && (((mkey[e] ^ k) & ~mmask[s]) == 8'h00);
            3'd3: if (mpend != '0) mpend[low_of(mpend)] = 1'b0;
            3'd4: begin mval[a] = 1'b0; mpend = '0; mfail = 1'b0; end
            3'd5: begin mmask[s] = k; mpend = '0; end
            default: ;
        endcase
        op_valid = 1'b1; op_code = c; op_key = k; op_data = d; op_addr = a; op_msel = s;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic check_state(input string req);
        int lo;
        logic eh, em;
        lo = low_of(mpend);
        eh = (lo >= 0);
        em = $countones(mpend) > 1;
        checks++;
        if (hit !== eh || multi_hit !== em) begin
            errors++;
            $display("FAIL %s hit/multi got %b/%b exp %b/%b", req, hit, multi_hit, eh, em);
        end else if (eh && (hit_addr !== 3'(lo) || hit_key !== mkey[lo] || hit_data !== mdat[lo])) begin
            errors++;
            $display("FAIL %s addr/key/data got %0d/%h/%h exp %0d/%h/%h", req,
                     hit_addr, hit_key, hit_data, lo, mkey[lo], mdat[lo]);
        end
    endtask

    task automatic check_fail(input string req);
        checks++;
        if (learn_fail !== mfail) begin
            errors++;
            $display("FAIL %s learn_fail got %b exp %b", req, learn_fail, mfail);
        end
    endtask

    // Search one comparand and walk all pending matches (R4 R5 R6 R7 R8).
    task automatic sweep(input string req);
        for (int s = 0; s < 4; s++)
            for (int k = 0; k < 256; k++) begin
                do_op(3'd2, 8'(k), 8'h00, 3'd0, 2'(s));
                check_state(req);
                while (mpend != '0) begin
                    do_op(3'd3, 8'h00, 8'h00, 3'd0, 2'd0);
                    check_state("R7");
                end
                do_op(3'd3, 8'h00, 8'h00, 3'd0, 2'd0);
                check_state("R8");
            end
    endtask

    initial begin
        logic [7:0] keys [N];
        keys = '{8'h12, 8'h13, 8'h22, 8'h32, 8'h1F, 8'hA2, 8'h12, 8'h55};
        for (int m = 0; m < 4; m++) mmask[m] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R12");
        check_fail("R12");
        // Search on empty store finds nothing.
        do_op(3'd2, 8'h12, 8'h00, 3'd0, 2'd0);
        check_state("R12");
        // Fill every slot with no address given.
        for (int e = 0; e < N; e++) begin
            do_op(3'd1, keys[e], 8'h80 + 8'(e), 3'd0, 2'd0);
            check_fail("R1");
        end
        // Learn into a full store fails and changes nothing.
        do_op(3'd1, 8'hEE, 8'h77, 3'd0, 2'd0);
        check_fail("R2");
        do_op(3'd2, 8'hEE, 8'h00, 3'd0, 2'd0);
        check_state("R2");
        // Duplicate key gives a multiple match with exact mask.
        do_op(3'd2, 8'h12, 8'h00, 3'd0, 2'd0);
        check_state("R6");
        // Mask registers: low nibble, high nibble, all don't-care.
        do_op(3'd5, 8'h0F, 8'h00, 3'd0, 2'd1);
        check_state("R9");
        do_op(3'd5, 8'hF0, 8'h00, 3'd0, 2'd2);
        do_op(3'd5, 8'hFF, 8'h00, 3'd0, 2'd3);
        // Same comparand, four masks give different match sets.
        for (int s = 0; s < 4; s++) begin
            do_op(3'd2, 8'h12, 8'h00, 3'd0, 2'(s));
            check_state("R11");
        end
        sweep("R3");
        // Pending result discarded by invalidate; dropped slot never matches.
        do_op(3'd2, 8'h00, 8'h00, 3'd0, 2'd3);
        check_state("R4");
        do_op(3'd4, 8'h00, 8'h00, 3'd0, 2'd0);
        check_state("R9");
        do_op(3'd4, 8'h00, 8'h00, 3'd6, 2'd0);
        do_op(3'd4, 8'h00, 8'h00, 3'd3, 2'd0);
        check_fail("R10");
        sweep("R10");
        // Relearn fills lowest free slot first; learn clears pending set.
        do_op(3'd2, 8'h00, 8'h00, 3'd0, 2'd3);
        do_op(3'd1, 8'h44, 8'h91, 3'd0, 2'd0);
        check_state("R9");
        do_op(3'd2, 8'h44, 8'h00, 3'd0, 2'd0);
        check_state("R1");
        do_op(3'd1, 8'h45, 8'h92, 3'd0, 2'd0);
        do_op(3'd1, 8'h46, 8'h93, 3'd0, 2'd0);
        do_op(3'd2, 8'h40, 8'h00, 3'd0, 2'd1);
        check_state("R5");
        do_op(3'd1, 8'h47, 8'h94, 3'd0, 2'd0);
        check_fail("R2");
        sweep("R4");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule